// File: doc/BRIEF.md
# Transmit Queue with Fill-Level Interrupts

This block buffers bytes between a host register-write port and a UART transmit serializer. Each host write lands in a 128-entry byte queue. The serializer takes the oldest byte through a start/done handshake. The current occupancy is visible to the host on every cycle.

Four sticky interrupt flags report events. The first reports that the occupancy has reached a programmable threshold, which is set in steps of eight entries. The second reports that the serializer has taken the last stored byte. The third reports that the serializer has finished that byte with nothing left behind it. The fourth reports that a write was lost because the queue was full.

The host can flush the queue in one cycle. It can also hold transmission off. When it does, the byte already being shifted finishes, but no new byte is handed over.

Top module: `txq_irq_top`

## Requirements
- R1: After reset, the fill level is 0, all four interrupt flags are 0, and `serStart` is low.
- R2: The serializer receives the bytes in the same order the host wrote them. `serData` carries the oldest byte in the cycle `serStart` is high.
- R3: The fill level changes by +1 for each accepted write and by -1 for each start pulse. It never exceeds 128.
- R4: A write to a full queue is discarded. The level stays at 128, and flag bit 3 (overflow) is set.
- R5: The threshold in entries is 8 × (`trigLevel` + 1). Flag bit 0 (trigger) is set in the cycle after the level first becomes greater than or equal to the threshold. Below the threshold it stays clear.
- R6: Flag bit 1 (queue empty) is set by the start pulse that takes the last stored byte. Earlier start pulses do not set it.
- R7: Flag bit 2 (transmitter empty) is set when `serDone` pulses while the level is 0. A done pulse while bytes remain does not set it.
- R8: `serStart` is high only when the level is non-zero, `txHold` is low and `serIdle` is high.
- R9: Raising `txHold` while a byte is being shifted lets that byte finish (its done still arrives). No further byte leaves the queue.
- R10: `qFlush` returns the level to 0 in the next cycle and discards all stored bytes. A write in the same cycle is also discarded.
- R11: Each flag stays set until its own bit of `irqClr` is pulsed, and only that flag clears. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| trigLevel | input | 4 | Threshold code, in units of eight entries |
| qFlush | input | 1 | Discard queue contents |
| txHold | input | 1 | Stop handing bytes to the serializer |
| irqClr | input | 4 | Per-flag clear strobes |
| fillLevel | output | 8 | Number of stored bytes, 0 to 128 |
| irqFlags | output | 4 | Sticky flags: 0 trigger, 1 queue empty, 2 transmitter empty, 3 overflow |
| serStart | output | 1 | Hand the head byte to the serializer |
| serData | output | 8 | Head byte |
| serIdle | input | 1 | Serializer can accept a byte |
| serDone | input | 1 | Serializer finished a byte |

## Verification
The threshold is swept over all sixteen codes. Each sweep writes one byte short of the threshold and then one byte onto it, which separates an off-by-one or wrong step size from a correct comparison.

A full 128-byte fill with a distinct arithmetic pattern, followed by a complete drain, checks ordering, pointer wrap and the overflow drop. Timing monitors separate the pulse that takes the last byte from the done pulse that ends it.

Short three- and five-byte bursts combined with hold and flush tell a clean stop after the current byte apart from a lost or duplicated byte.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int NUM_IRQ   = 4;
  localparam int IRQ_TRIG  = 0;
  localparam int IRQ_QEMPT = 1;
  localparam int IRQ_TXEMP = 2;
  localparam int IRQ_OVF   = 3;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txqStrobe_t;
endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign level    = count;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.pop && !ctl.flush) |=> count == $past(count) + 1'b1);
  // R4
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> count < CNT_W'(DEPTH));
  // R8
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> count != '0);
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> count == '0);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int TRIG_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int STEP  = DEPTH >> TRIG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               qFlush,
  input  logic               txHold,
  input  logic [TRIG_W-1:0]  trigLevel,
  input  logic [NUM_IRQ-1:0] irqClr,
  input  logic [CNT_W-1:0]   level,
  input  logic               serIdle,
  input  logic               serDone,
  output txqStrobe_t         ctl,
  output logic               serStart,
  output logic [NUM_IRQ-1:0] irqFlags
);
  logic [CNT_W-1:0]   thresh;
  logic               isFull, hit, prevHit;
  logic [NUM_IRQ-1:0] setVec, flagQ;

  assign isFull   = (level == CNT_W'(DEPTH));
  assign thresh   = (CNT_W'(trigLevel) + CNT_W'(1)) * CNT_W'(STEP);
  assign hit      = (level >= thresh);

  assign ctl.flush = qFlush;
  assign ctl.push  = wrEn && !isFull && !qFlush;
  assign ctl.pop   = (level != '0) && !txHold && serIdle && !qFlush;
  assign serStart  = ctl.pop;

  always_comb begin
    setVec            = '0;
    setVec[IRQ_TRIG]  = hit && !prevHit;
    setVec[IRQ_QEMPT] = ctl.pop && (level == CNT_W'(1)) && !ctl.push;
    setVec[IRQ_TXEMP] = serDone && (level == '0);
    setVec[IRQ_OVF]   = wrEn && isFull && !qFlush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHit <= 1'b0;
      flagQ   <= '0;
    end else begin
      prevHit <= hit;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (setVec[i])      flagQ[i] <= 1'b1;
        else if (irqClr[i]) flagQ[i] <= 1'b0;
      end
    end
  end

  assign irqFlags = flagQ;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_stick
    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlags[g] && !irqClr[g]) |=> irqFlags[g]);
  end

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && level == CNT_W'(DEPTH) && !qFlush) |=> irqFlags[IRQ_OVF]);
  // R7
  txemp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serDone && level == '0) |=> irqFlags[IRQ_TXEMP]);
  // R9
  hold_nostart_chk: assert property (@(posedge clk) disable iff (!rstN)
    txHold |-> !serStart);
endmodule

// File: rtl/txq_irq_top.sv
module txq_irq_top
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int TRIG_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [TRIG_W-1:0]  trigLevel,
  input  logic               qFlush,
  input  logic               txHold,
  input  logic [NUM_IRQ-1:0] irqClr,
  output logic [CNT_W-1:0]   fillLevel,
  output logic [NUM_IRQ-1:0] irqFlags,
  output logic               serStart,
  output logic [DATA_W-1:0]  serData,
  input  logic               serIdle,
  input  logic               serDone
);
  txqStrobe_t       ctl;
  logic [CNT_W-1:0] level;

  txq_ctrl #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .qFlush(qFlush), .txHold(txHold),
    .trigLevel(trigLevel), .irqClr(irqClr), .level(level),
    .serIdle(serIdle), .serDone(serDone), .ctl(ctl),
    .serStart(serStart), .irqFlags(irqFlags)
  );

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .headData(serData), .level(level)
  );

  assign fillLevel = level;
endmodule

// File: tb/txq_irq_top_bench.sv
module txq_irq_top_bench;
  localparam int SER_LEN = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] trigLevel = '0;
  logic       qFlush = 1'b0;
  logic       txHold = 1'b1;
  logic [3:0] irqClr = '0;
  logic [7:0] fillLevel;
  logic [3:0] irqFlags;
  logic       serStart;
  logic [7:0] serData;
  logic       serIdle;
  logic       serDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit monOn = 0;

  always #5 clk = ~clk;

  txq_irq_top u_txq_irq_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .trigLevel(trigLevel), .qFlush(qFlush), .txHold(txHold), .irqClr(irqClr),
    .fillLevel(fillLevel), .irqFlags(irqFlags), .serStart(serStart),
    .serData(serData), .serIdle(serIdle), .serDone(serDone)
  );

  // serializer model
  logic       busy;
  int         bitCnt;
  logic [7:0] logBuf [512];
  int         nLog = 0;
  int         nStart = 0;
  int         nDone = 0;
  logic       doneQ;

  assign serIdle = !busy;
  assign serDone = doneQ;

  always @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= 0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (busy) begin
        bitCnt <= bitCnt + 1;
        if (bitCnt == SER_LEN - 1) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
          nDone <= nDone + 1;
        end
      end else if (serStart) begin
        busy         <= 1'b1;
        bitCnt       <= 0;
        logBuf[nLog] <= serData;
        nLog         <= nLog + 1;
        nStart       <= nStart + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // timing monitor for the two empty flags and the start gate
  bit pendEmpty = 0;
  bit pendTx = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (serStart)
        chk(serIdle && !txHold && fillLevel != 0, "R8 start gate", int'(serStart), 0);
      if (monOn) begin
        if (pendEmpty) chk(irqFlags[1] == 1'b1, "R6 queue-empty on last start", int'(irqFlags[1]), 1);
        if (pendTx)    chk(irqFlags[2] == 1'b1, "R7 tx-empty on final done", int'(irqFlags[2]), 1);
        pendEmpty = 0;
        pendTx = 0;
        if (serStart && fillLevel == 8'd1) pendEmpty = 1;
        else if (serStart) chk(irqFlags[1] == 1'b0, "R6 not set early", int'(irqFlags[1]), 0);
        if (serDone && fillLevel == 8'd0) pendTx = 1;
        else if (serDone) chk(irqFlags[2] == 1'b0, "R7 not set with bytes left", int'(irqFlags[2]), 0);
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic flush();
    @(negedge clk); qFlush = 1'b1;
    @(negedge clk); qFlush = 1'b0;
  endtask

  task automatic clr(input logic [3:0] v);
    @(negedge clk); irqClr = v;
    @(negedge clk); irqClr = '0;
  endtask

  task automatic waitDrain();
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (fillLevel == 0 && serIdle) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    int s0;
    int d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(fillLevel == 0, "R1 level", fillLevel, 0);
    chk(irqFlags == 0, "R1 flags", irqFlags, 0);
    chk(serStart == 0, "R1 start", serStart, 0);

    // R5 sweep every threshold code
    for (int tl = 0; tl < 16; tl++) begin
      flush();
      trigLevel = 4'(tl);
      clr(4'hF);
      for (int n = 0; n < 8 * (tl + 1) - 1; n++) wr(8'(n));
      chk(fillLevel == 8'(8 * (tl + 1) - 1), "R3 level below threshold", fillLevel, 8 * (tl + 1) - 1);
      chk(irqFlags[0] == 1'b0, "R5 below threshold", irqFlags[0], 0);
      wr(8'hC3);
      chk(irqFlags[0] == 1'b1, "R5 at threshold", irqFlags[0], 1);
    end

    // R2/R3/R5 full fill with pattern, threshold 32
    flush();
    trigLevel = 4'd3;
    clr(4'hF);
    for (int i = 0; i < 128; i++) begin
      wr(8'((i * 7 + 3) & 255));
      chk(fillLevel == 8'(i + 1), "R3 level on fill", fillLevel, i + 1);
      chk(irqFlags[0] == ((i + 1) >= 32), "R5 trigger on fill", irqFlags[0], int'((i + 1) >= 32));
    end

    // R4 overflow drop
    wr(8'hEE);
    chk(fillLevel == 8'd128, "R4 level stays full", fillLevel, 128);
    chk(irqFlags[3] == 1'b1, "R4 overflow flag", irqFlags[3], 1);

    // R9 hold: nothing leaves while held
    chk(serStart == 1'b0, "R9 hold blocks start", serStart, 0);

    // R2/R6/R7 drain everything
    clr(4'hF);
    base = nLog;
    monOn = 1;
    @(negedge clk); txHold = 1'b0;
    waitDrain();
    monOn = 0;
    txHold = 1'b1;
    chk(nLog - base == 128, "R2 byte count", nLog - base, 128);
    for (int i = 0; i < 128; i++)
      chk(logBuf[base + i] == 8'((i * 7 + 3) & 255), "R2 order", logBuf[base + i], (i * 7 + 3) & 255);
    chk(irqFlags[1] == 1'b1, "R6 flag after drain", irqFlags[1], 1);
    chk(irqFlags[2] == 1'b1, "R7 flag after drain", irqFlags[2], 1);

    // R11 per-bit clear
    clr(4'b0010);
    chk(irqFlags == 4'b0100, "R11 only bit1 cleared", irqFlags, 4);

    // R11 set beats clear (trigger at 8 entries)
    flush();
    trigLevel = 4'd0;
    clr(4'hF);
    for (int n = 0; n < 7; n++) wr(8'(n));
    @(negedge clk); wrEn = 1'b1; wrData = 8'h08; irqClr = 4'b0001;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk); irqClr = '0;
    chk(irqFlags[0] == 1'b1, "R11 set wins over clear", irqFlags[0], 1);

    // R9 hold mid-character
    flush();
    wr(8'hA1); wr(8'hA2); wr(8'hA3);
    base = nLog; s0 = nStart; d0 = nDone;
    @(negedge clk); txHold = 1'b0;
    #1 chk(serStart == 1'b1, "R8 start when released", serStart, 1);
    @(posedge clk);
    @(negedge clk); txHold = 1'b1;
    repeat (30) @(negedge clk);
    chk(nStart - s0 == 1, "R9 one start", nStart - s0, 1);
    chk(nDone - d0 == 1, "R9 current byte finished", nDone - d0, 1);
    chk(fillLevel == 8'd2, "R9 level held", fillLevel, 2);
    txHold = 1'b0;
    waitDrain();
    txHold = 1'b1;
    chk(nLog - base == 3, "R9 total after release", nLog - base, 3);
    chk(logBuf[base] == 8'hA1 && logBuf[base + 1] == 8'hA2 && logBuf[base + 2] == 8'hA3,
        "R2 order after hold", logBuf[base + 2], 8'hA3);

    // R10 flush with simultaneous write
    for (int n = 0; n < 5; n++) wr(8'(8'h50 + n));
    @(negedge clk); qFlush = 1'b1; wrEn = 1'b1; wrData = 8'h77;
    @(negedge clk); qFlush = 1'b0; wrEn = 1'b0;
    chk(fillLevel == 8'd0, "R10 flush level", fillLevel, 0);
    base = nLog;
    wr(8'h11); wr(8'h22);
    chk(fillLevel == 8'd2, "R10 level after refill", fillLevel, 2);
    txHold = 1'b0;
    waitDrain();
    txHold = 1'b1;
    chk(nLog - base == 2, "R10 old bytes gone", nLog - base, 2);
    chk(logBuf[base] == 8'h11, "R10 first byte", logBuf[base], 8'h11);
    chk(logBuf[base + 1] == 8'h22, "R10 second byte", logBuf[base + 1], 8'h22);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule